// File: doc/BRIEF.md
# Programmable Power-of-Two Timer with Single-Shot Output

This block is a synchronous divider and one-shot timer. A 16-bit binary count advances on every system clock cycle in which the `tick` enable is high. Two select inputs choose which count bit drives the output. The available taps are stage 8, stage 10, stage 13 and stage 16, so the output period is 2^8, 2^10, 2^13 or 2^16 ticks. For the shortest setting, the tick drives the upper eight count bits directly, and the stage-16 tap then divides by 2^8.

An output stage provides two behaviours. In recycle mode the selected bit drives the output continuously, so the block works as a free-running divider. In single-cycle mode the output changes level once, after half of the selected period, and then stays there. It is re-armed only by a reset or by a change of the mode input.

A polarity input sets the output level while the block is in reset and inverts the active level. Two reset requests clear the block: an active-high master reset, and a power-on reset request that acts only while the auto-reset disable input is low.

Top module: `prog_tick_timer`

## Requirements
- R1: The select pair {sel_a, sel_b} picks the tap as follows: 2'b00 selects stage 13 (first output change after 4096 ticks), 2'b01 selects stage 10 (after 512 ticks), and 2'b11 selects stage 16 (after 32768 ticks).
- R2: With sel_a=1 and sel_b=0, the tick drives the upper eight count bits directly, so the stage-16 tap changes level every 128 ticks.
- R3: The count advances only on rising clock edges at which `tick` is 1. Cycles with `tick`=0 leave the output timing unchanged.
- R4: `mreset`=1 clears the count and the single-shot latch, whatever their state. Ticks that arrive while it is held are dropped. Counting restarts from zero after it is released.
- R5: `por_req`=1 clears the block like `mreset` when `auto_off`=0. When `auto_off`=1 it has no effect.
- R6: While any clear request (master, power-on or mode change) is active, `q_out` equals `pol`.
- R7: With `recycle`=1, `q_out` equals the selected count bit XOR `pol`. It changes level every 2^(n-1) ticks.
- R8: With `recycle`=0, `q_out` starts at `pol`, changes to the opposite level once after 2^(n-1) ticks, and then holds that level however many further ticks arrive.
- R9: Any change of `recycle` causes a one-cycle internal clear of the count and latch. This re-arms the single shot.
- R10: The asynchronous system reset `rst_n`=0 clears the count, the latch and the stored mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick | input | 1 | Count enable, one count per high cycle |
| sel_a | input | 1 | Tap select, high bit |
| sel_b | input | 1 | Tap select, low bit |
| recycle | input | 1 | 1 = free-running divider, 0 = single shot |
| pol | input | 1 | Output level during clear and output inversion |
| mreset | input | 1 | Active-high master clear |
| por_req | input | 1 | Power-on clear request |
| auto_off | input | 1 | 1 disables the power-on clear request |
| q_out | output | 1 | Timer output |

## Verification
On every cycle the assertions check the following:
- a clear leaves the count at zero;
- an idle cycle leaves the count unchanged;
- the lower half carries into the upper half only on a wrap, or on every tick when the short tap is rerouted;
- a fired single-shot latch stays set;
- a mode change empties the latch.

The exact tick at which the output changes level for each select code, mode and polarity can only be shown by the bench's sweeps. The same holds for the hold after the single shot, the power-on request being ignored when auto-reset is disabled, and re-arming after a mode change.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;
    localparam int TT_CNT_W = 16;
    localparam int TT_LOW_W = 8;

    typedef enum logic [1:0] {
        SEL_STAGE13 = 2'b00,
        SEL_STAGE10 = 2'b01,
        SEL_SHORT   = 2'b10,
        SEL_STAGE16 = 2'b11
    } tt_sel_e;

    typedef struct packed {
        logic fired;
        logic mode_prev;
    } shot_state_t;
endpackage

// File: rtl/tt_chain_count.sv
`timescale 1ns/1ps
module tt_chain_count #(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             reroute,
    output logic [CNT_W-1:0] cnt_q
);
    localparam int HIGH_W = CNT_W - LOW_W;

    typedef struct packed {
        logic [HIGH_W-1:0] hi;
        logic [LOW_W-1:0]  lo;
    } chain_t;

    chain_t st_q, st_d;
    logic   lo_wrap;
    logic   hi_step;

    always_comb begin
        st_d    = st_q;
        lo_wrap = &st_q.lo;
        hi_step = reroute ? tick : (tick & lo_wrap);
        if (clr) begin
            st_d = '0;
        end else begin
            if (tick)    st_d.lo = st_q.lo + 1'b1;
            if (hi_step) st_d.hi = st_q.hi + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = {st_q.hi, st_q.lo};

    // R4: a clear empties every stage
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    // R3: no tick, no movement
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));
    // R2: rerouted upper half steps on every tick
    a_r2_upper_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (reroute && tick && !clr) |=> (st_q.hi == HIGH_W'($past(st_q.hi) + 1'b1)));
    // R1: normal chain carries only on lower wrap
    a_r1_carry_only_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!reroute && !clr && !(tick && lo_wrap)) |=> $stable(st_q.hi));
endmodule

// File: rtl/tt_tap_pick.sv
`timescale 1ns/1ps
module tt_tap_pick
    import tt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TAP_MID  = 10,
    parameter int TAP_LONG = 13,
    parameter int TAP_FULL = 16
) (
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic [CNT_W-1:0] cnt,
    output logic             tap,
    output logic             reroute
);
    tt_sel_e sel;

    always_comb begin
        sel     = tt_sel_e'({sel_a, sel_b});
        reroute = 1'b0;
        tap     = 1'b0;
        unique case (sel)
            SEL_STAGE13: tap = cnt[TAP_LONG-1];
            SEL_STAGE10: tap = cnt[TAP_MID-1];
            SEL_SHORT: begin
                tap     = cnt[TAP_FULL-1];
                reroute = 1'b1;
            end
            SEL_STAGE16: tap = cnt[TAP_FULL-1];
            default:     tap = 1'b0;
        endcase
    end
endmodule

// File: rtl/tt_shot_ctl.sv
`timescale 1ns/1ps
module tt_shot_ctl
    import tt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_ext,
    input  logic recycle,
    input  logic pol,
    input  logic tap,
    output logic clr_all,
    output logic q_out
);
    shot_state_t st_q, st_d;
    logic        mode_flip;
    logic        level;

    always_comb begin
        mode_flip      = recycle ^ st_q.mode_prev;
        clr_all        = clr_ext | mode_flip;
        st_d.mode_prev = recycle;
        st_d.fired     = clr_all ? 1'b0 : (st_q.fired | tap);
        level          = recycle ? tap : (st_q.fired | tap);
        q_out          = clr_all ? pol : (pol ^ level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: once fired, the single shot holds until a clear
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!recycle && st_q.fired && !clr_all) |=> st_q.fired);
    // R9: a mode change empties the latch
    a_r9_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flip |=> !st_q.fired);
    // R9: the stored mode follows the input one cycle later
    a_r9_mode_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.mode_prev == $past(recycle)));
endmodule

// File: rtl/prog_tick_timer.sv
`timescale 1ns/1ps
module prog_tick_timer
    import tt_pkg::*;
#(
    parameter int CNT_W    = TT_CNT_W,
    parameter int TAP_SHORT = TT_LOW_W,
    parameter int TAP_MID  = 10,
    parameter int TAP_LONG = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sel_a,
    input  logic sel_b,
    input  logic recycle,
    input  logic pol,
    input  logic mreset,
    input  logic por_req,
    input  logic auto_off,
    output logic q_out
);
    logic [CNT_W-1:0] cnt;
    logic             tap;
    logic             reroute;
    logic             clr_ext;
    logic             clr_all;

    assign clr_ext = mreset | (por_req & ~auto_off);

    tt_chain_count #(.CNT_W(CNT_W), .LOW_W(TAP_SHORT)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .tick(tick),
        .reroute(reroute), .cnt_q(cnt)
    );

    tt_tap_pick #(.CNT_W(CNT_W), .TAP_MID(TAP_MID), .TAP_LONG(TAP_LONG),
                  .TAP_FULL(CNT_W)) u_pick (
        .sel_a(sel_a), .sel_b(sel_b), .cnt(cnt), .tap(tap), .reroute(reroute)
    );

    tt_shot_ctl u_shot (
        .clk(clk), .rst_n(rst_n), .clr_ext(clr_ext), .recycle(recycle),
        .pol(pol), .tap(tap), .clr_all(clr_all), .q_out(q_out)
    );

    // R5: a master or enabled power-on request always clears
    a_r5_request_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mreset || (por_req && !auto_off)) |=> (cnt == '0));
endmodule

// File: tb/prog_tick_timer_test.sv
`timescale 1ns/1ps
module prog_tick_timer_test;
    logic clk = 1'b0;
    logic rst_n, tick, sel_a, sel_b, recycle, pol, mreset, por_req, auto_off;
    logic q_out;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    prog_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_a(sel_a), .sel_b(sel_b),
        .recycle(recycle), .pol(pol), .mreset(mreset), .por_req(por_req),
        .auto_off(auto_off), .q_out(q_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic expv(input int i, input int half, input logic md, input logic p);
        if (md) return p ^ (((i / half) % 2) == 1);
        return p ^ (i >= half);
    endfunction

    // master clear with new settings; ends just after a negedge with tick low
    task automatic apply_clear(input logic a, input logic b, input logic md, input logic p);
        @(negedge clk);
        sel_a = a; sel_b = b; recycle = md; pol = p; mreset = 1'b1; tick = 1'b1;
        @(posedge clk); #1;
        chk("R6 level during master clear", q_out, p);
        @(negedge clk);
        mreset = 1'b0; tick = 1'b0;
        #1 chk("R4 cleared start level", q_out, p);
    endtask

    task automatic run(input int half, input int limit, input string req);
        tick = 1'b1;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); #1;
            if (i == half - 1 || i == half || i == 2 * half - 1 || i == 2 * half)
                chk(req, q_out, expv(i, half, recycle, pol));
        end
    endtask

    task automatic one(input logic t, input logic por);
        @(negedge clk);
        tick = t; por_req = por;
        @(posedge clk); #1;
    endtask

    task automatic ones(input int k);
        for (int i = 0; i < k; i++) one(1'b1, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b0; sel_a = 1'b0; sel_b = 1'b0; recycle = 1'b0;
        pol = 1'b0; mreset = 1'b0; por_req = 1'b0; auto_off = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk("R10 reset state", q_out, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // R1 R7 R8 sweeps over codes 10 (R2), 01, 00
        for (int c = 0; c < 3; c++) begin
            for (int m = 0; m < 2; m++) begin
                for (int p = 0; p < 2; p++) begin
                    int half;
                    logic a, b;
                    half = (c == 0) ? 128 : ((c == 1) ? 512 : 4096);
                    a = (c == 0); b = (c == 1);
                    apply_clear(a, b, m[0], p[0]);
                    if (c == 0) run(half, 2 * half + 2, m ? "R2 R7 short recycle" : "R2 R8 short single");
                    else        run(half, 2 * half + 2, m ? "R1 R7 recycle" : "R1 R8 single hold");
                end
            end
        end
        // R1 stage 16 in both modes
        for (int m = 0; m < 2; m++) begin
            apply_clear(1'b1, 1'b1, m[0], 1'b0);
            run(32768, 32770, "R1 stage16 first change");
        end

        // R3 gapped ticks
        apply_clear(1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 127; i++) begin one(1'b1, 1'b0); one(1'b0, 1'b0); end
        chk("R3 127 gapped ticks", q_out, 1'b0);
        repeat (3) one(1'b0, 1'b0);
        chk("R3 idle cycles no count", q_out, 1'b0);
        one(1'b1, 1'b0);
        chk("R3 128th tick", q_out, 1'b1);

        // R5 power-on request ignored when disabled
        auto_off = 1'b1;
        apply_clear(1'b1, 1'b0, 1'b1, 1'b0);
        ones(50);
        one(1'b1, 1'b1);
        ones(76);
        chk("R5 ignored por 127", q_out, 1'b0);
        ones(1);
        chk("R5 ignored por 128", q_out, 1'b1);
        // R5 power-on request honoured when enabled
        auto_off = 1'b0;
        apply_clear(1'b1, 1'b0, 1'b1, 1'b0);
        ones(50);
        one(1'b1, 1'b1);
        chk("R6 level during por clear", q_out, 1'b0);
        ones(127);
        chk("R5 por restart 127", q_out, 1'b0);
        ones(1);
        chk("R5 por restart 128", q_out, 1'b1);
        auto_off = 1'b1;

        // R8 then R9 re-arm by mode change
        apply_clear(1'b1, 1'b0, 1'b0, 1'b1);
        ones(200);
        chk("R8 fired and held", q_out, 1'b0);
        @(negedge clk); recycle = 1'b1; tick = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); recycle = 1'b0;
        @(posedge clk); #1;
        chk("R9 mode change clears", q_out, 1'b1);
        ones(127);
        chk("R9 re-armed 127", q_out, 1'b1);
        ones(1);
        chk("R9 re-armed 128", q_out, 1'b0);

        // R4 mid-count master clear with ticks held
        ones(60);
        apply_clear(1'b1, 1'b0, 1'b0, 1'b1);
        ones(127);
        chk("R4 restart after clear 127", q_out, 1'b1);
        ones(1);
        chk("R4 restart after clear 128", q_out, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule